// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs one complete Clause 22 style management transaction against an external PHY. A one-cycle start request supplies a direction flag, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. The block then produces the management clock (MDC) from the system clock. Each MDC half period lasts a fixed number of system clocks set by a parameter. The block drives the data line through a tristate output made of an output value, an output enable and an input.

Every frame starts with a long all-ones preamble. Frames use a fixed turnaround scheme. On a read the master releases the line for one turnaround MDC cycle and then shifts in 16 bits. On a write it drives the turnaround itself. Both kinds of frame end with one extra MDC cycle with the line released. Completion is signalled by a one-cycle done pulse, and for a read the returned data is valid in that cycle.

Top module: `mdio_master`

## Requirements
- R1: When idle (busy_o low), mdc_o is 0 and mdio_oe_o is 0. This also holds right after reset, and done_o is 0 after reset.
- R2: Each frame opens with PRE_LEN (default 40) MDC cycles, each carrying 1 with mdio_oe_o high.
- R3: After the preamble the master sends 0 then 1. It then sends the opcode, which is 1,0 when rd_i=1 (read) and 0,1 when rd_i=0 (write).
- R4: The opcode is followed by phy_addr_i, MSB first, and then by reg_addr_i, MSB first, five bits each.
- R5: Each MDC low half and each high half lasts HALF_DIV system clocks. mdio_o and mdio_oe_o only change while mdc_o is low.
- R6: On a read, mdio_oe_o drops right after the last register address bit and stays low for the rest of the frame. After one turnaround MDC cycle, 16 data bits are shifted into rdata_o MSB first. Each bit is mdio_i as sampled on the system clock edge at which mdc_o rises.
- R7: On a write, the two MDC cycles after the register address drive 1 then 0. They are followed by wdata_i, MSB first, with mdio_oe_o high.
- R8: Each frame ends with one MDC cycle with mdio_oe_o low. A read frame is PRE_LEN+32 MDC cycles long and a write frame is PRE_LEN+33.
- R9: busy_o rises the cycle after an accepted start and stays high for exactly (frame MDC cycles)×2×HALF_DIV clocks. done_o is high for one clock, in the first cycle with busy_o low, and rdata_o then holds the read data.
- R10: A start_i pulse while busy_o is high is ignored. The running frame, its length and its done pulse are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken when idle |
| rd_i | input | 1 | 1 = read, 0 = write |
| phy_addr_i | input | 5 | PHY address |
| reg_addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid with done_o |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The PHY model changes mdio_i in the same system cycle that MDC rises. A design that samples even one clock late therefore collects a bit-shifted word, and one that samples from the turnaround slot collects an extra leading bit. The bench records the line at every MDC rise and compares the recorded frame region by region. This catches a swapped opcode, address bits sent LSB first, an output enable held through the read turnaround, and a missing trailing clock (which would show as a wrong frame length). A start pulse is injected in the middle of a frame. A design that restarts on it would show a corrupted frame or a busy period of the wrong length. Walking-one and all-ones/all-zeros data patterns catch a dropped or duplicated data bit.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 16;
  typedef logic [ADDR_W-1:0] mdio_addr_t;
  typedef logic [DATA_W-1:0] mdio_data_t;
endpackage

// File: rtl/mdio_half_timer.sv
module mdio_half_timer #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             bit_i,
  output logic [WIDTH-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   data_o <= '0;
    else if (en_i) data_o <= {data_o[WIDTH-2:0], bit_i};
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned HALF_DIV = 4,
  parameter int unsigned PRE_LEN  = 40
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       rd_i,
  input  mdio_addr_t phy_addr_i,
  input  mdio_addr_t reg_addr_i,
  input  mdio_data_t wdata_i,
  output mdio_data_t rdata_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       mdc_o,
  output logic       mdio_o,
  output logic       mdio_oe_o,
  input  logic       mdio_i
);
  // frame layout in MDC cycles
  localparam int unsigned HDR_LEN  = PRE_LEN + 4 + 2 * ADDR_W;
  localparam int unsigned WR_DRV   = HDR_LEN + 2 + DATA_W;
  localparam int unsigned RD_SLOTS = HDR_LEN + 1 + DATA_W + 1;
  localparam int unsigned WR_SLOTS = WR_DRV + 1;
  localparam int unsigned SLOT_W   = $clog2(WR_SLOTS + 1);
  localparam int unsigned RD_FIRST = HDR_LEN + 1;
  localparam int unsigned RD_LAST  = HDR_LEN + DATA_W;

  logic              busy_q, done_q, high_q, rd_q;
  logic [SLOT_W-1:0] slot_q;
  logic [WR_DRV-1:0] frame_q;
  logic              tick;
  logic              smp_en;
  logic [SLOT_W-1:0] last_slot, drv_end;

  mdio_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_q),
    .tick_o (tick)
  );

  assign last_slot = rd_q ? SLOT_W'(RD_SLOTS - 1) : SLOT_W'(WR_SLOTS - 1);
  assign drv_end   = rd_q ? SLOT_W'(HDR_LEN)      : SLOT_W'(WR_DRV);

  // sample on the edge that raises MDC
  assign smp_en = tick && !high_q && rd_q &&
                  (slot_q >= SLOT_W'(RD_FIRST)) && (slot_q <= SLOT_W'(RD_LAST));

  mdio_rx_shift #(.WIDTH(DATA_W)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (smp_en),
    .bit_i  (mdio_i),
    .data_o (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      high_q  <= 1'b0;
      rd_q    <= 1'b0;
      slot_q  <= '0;
      frame_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q  <= 1'b1;
          high_q  <= 1'b0;
          slot_q  <= '0;
          rd_q    <= rd_i;
          frame_q <= {{PRE_LEN{1'b1}}, 2'b01, rd_i, !rd_i,
                      phy_addr_i, reg_addr_i, 2'b10, wdata_i};
        end
      end else if (tick) begin
        if (!high_q) begin
          high_q <= 1'b1;
        end else begin
          high_q  <= 1'b0;
          frame_q <= frame_q << 1;
          if (slot_q == last_slot) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            slot_q <= slot_q + 1'b1;
          end
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign mdc_o     = busy_q && high_q;
  assign mdio_oe_o = busy_q && (slot_q < drv_end);
  assign mdio_o    = mdio_oe_o && frame_q[WR_DRV-1];
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic mdc_o,
  input logic mdio_o,
  input logic mdio_oe_o
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mdc_o && !mdio_oe_o));

  // R5
  stable_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

  // R9
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R9
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  // R10
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .mdc_o     (mdc_o),
  .mdio_o    (mdio_o),
  .mdio_oe_o (mdio_oe_o)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  localparam int HALF = 3;
  localparam int PRE  = 40;
  localparam int HDR  = PRE + 14;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [4:0]  phy_addr_i = '0;
  logic [4:0]  reg_addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        busy_o, done_o, mdc_o, mdio_o, mdio_oe_o;
  logic        mdio_i;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // monitor state
  int   rise_cnt = 0;
  int   busy_cyc = 0;
  int   done_cyc = 0;
  int   hi_chg   = 0;
  logic prev_mdc = 0, prev_o = 0, prev_oe = 0;
  logic rec_o  [0:127];
  logic rec_oe [0:127];

  // PHY model
  logic        m_rd = 0;
  logic [15:0] m_data = '0;

  always #5 clk_i = ~clk_i;

  mdio_master #(.HALF_DIV(HALF), .PRE_LEN(PRE)) u_mdio_master (
    .clk_i, .rst_ni, .start_i, .rd_i, .phy_addr_i, .reg_addr_i, .wdata_i,
    .rdata_o, .busy_o, .done_o, .mdc_o, .mdio_o, .mdio_oe_o, .mdio_i
  );

  // bit changes as MDC rises, so late sampling picks the next bit
  assign mdio_i = (m_rd && rise_cnt >= HDR + 1 && rise_cnt <= HDR + 16)
                  ? m_data[HDR + 16 - rise_cnt] : 1'b1;

  always @(negedge clk_i) begin
    if (mdc_o && !prev_mdc) begin
      if (rise_cnt < 128) begin
        rec_o[rise_cnt]  = mdio_o;
        rec_oe[rise_cnt] = mdio_oe_o;
      end
      rise_cnt = rise_cnt + 1;
    end
    if (mdc_o && prev_mdc && (mdio_o != prev_o || mdio_oe_o != prev_oe))
      hi_chg = hi_chg + 1;
    if (busy_o) busy_cyc = busy_cyc + 1;
    if (done_o) done_cyc = done_cyc + 1;
    prev_mdc = mdc_o;
    prev_o   = mdio_o;
    prev_oe  = mdio_oe_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic int slots_of(bit rd);
    return rd ? HDR + 18 : HDR + 19;
  endfunction

  function automatic bit exp_oe(bit rd, int s);
    return rd ? (s < HDR) : (s < HDR + 18);
  endfunction

  function automatic bit exp_bit(bit rd, logic [4:0] pa, logic [4:0] ra,
                                 logic [15:0] wd, int s);
    if (s < PRE)      return 1'b1;
    if (s == PRE)     return 1'b0;
    if (s == PRE + 1) return 1'b1;
    if (s == PRE + 2) return rd;
    if (s == PRE + 3) return !rd;
    if (s < PRE + 9)  return pa[4 - (s - PRE - 4)];
    if (s < HDR)      return ra[4 - (s - PRE - 9)];
    if (s == HDR)     return 1'b1;
    if (s == HDR + 1) return 1'b0;
    return wd[15 - (s - HDR - 2)];
  endfunction

  task automatic run_txn(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] wd, input logic [15:0] md, input bit inject);
    int e_pre = 0, e_st = 0, e_addr = 0, e_ta = 0, e_dat = 0, e_oe = 0;
    int n;
    bit seen = 0;
    @(negedge clk_i);
    m_rd = rd; m_data = md;
    rise_cnt = 0; busy_cyc = 0; done_cyc = 0; hi_chg = 0;
    start_i = 1; rd_i = rd; phy_addr_i = pa; reg_addr_i = ra; wdata_i = wd;
    @(negedge clk_i);
    start_i = 0;
    phy_addr_i = ~pa; reg_addr_i = ~ra; wdata_i = ~wd; rd_i = ~rd;
    for (int k = 0; k < 2000 && !seen; k++) begin
      @(negedge clk_i);
      if (done_o) seen = 1;
      start_i = inject && (k == 100);
    end
    start_i = 0;
    chk(seen, "R9 done seen", seen, 1);
    if (seen) chk(rdata_o == (rd ? md : rdata_o), "R6 read data", rdata_o, md);
    @(negedge clk_i);
    n = slots_of(rd);
    chk(rise_cnt == n, "R8 frame length", rise_cnt, n);
    for (int s = 0; s < n && s < 128; s++) begin
      if (rec_oe[s] != exp_oe(rd, s)) e_oe++;
      if (exp_oe(rd, s) && rec_o[s] != exp_bit(rd, pa, ra, wd, s)) begin
        if (s < PRE) e_pre++;
        else if (s < PRE + 4) e_st++;
        else if (s < HDR) e_addr++;
        else if (s < HDR + 2) e_ta++;
        else e_dat++;
      end
    end
    chk(e_pre == 0, "R2 preamble", e_pre, 0);
    chk(e_st == 0, "R3 start/opcode", e_st, 0);
    chk(e_addr == 0, "R4 addresses", e_addr, 0);
    chk(e_oe == 0, rd ? "R6 release pattern" : "R8 release pattern", e_oe, 0);
    if (!rd) chk(e_ta + e_dat == 0, "R7 turnaround/data", e_ta + e_dat, 0);
    chk(hi_chg == 0, "R5 change while mdc high", hi_chg, 0);
    chk(busy_cyc == n * 2 * HALF, inject ? "R10 busy length" : "R9 busy length",
        busy_cyc, n * 2 * HALF);
    chk(done_cyc == 1, inject ? "R10 done count" : "R9 done count", done_cyc, 1);
    chk(!busy_o && !mdc_o && !mdio_oe_o, "R1 idle after frame",
        {busy_o, mdc_o, mdio_oe_o}, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk(!mdc_o && !mdio_oe_o && !busy_o && !done_o, "R1 reset state",
        {mdc_o, mdio_oe_o, busy_o, done_o}, 0);
    // directed corners
    run_txn(1'b0, 5'h00, 5'h1f, 16'hffff, 16'h0000, 1'b0);
    run_txn(1'b0, 5'h1f, 5'h00, 16'h0000, 16'h0000, 1'b0);
    run_txn(1'b1, 5'h01, 5'h10, 16'h0000, 16'ha5a5, 1'b0);
    run_txn(1'b1, 5'h10, 5'h01, 16'h0000, 16'h8001, 1'b0);
    run_txn(1'b1, 5'h15, 5'h0a, 16'h0000, 16'hffff, 1'b0);
    run_txn(1'b1, 5'h0a, 5'h15, 16'h0000, 16'h0000, 1'b1);
    run_txn(1'b0, 5'h0a, 5'h15, 16'h1234, 16'h0000, 1'b1);
    for (int b = 0; b < 16; b += 5)
      run_txn(1'b1, 5'(b), 5'(15 - b), 16'h0000, 16'h1 << b, 1'b0);
    // random
    for (int i = 0; i < 20; i++)
      run_txn(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom),
              16'($urandom), 1'($urandom_range(0, 3) == 0));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule